// File: doc/BRIEF.md
# Embedded Controller Host Mailbox

This block is the device side of a two-port embedded-controller mailbox on a byte-wide host I/O bus. The host sees a data port and a shared port that returns status when read and accepts a command when written. Each byte the host writes raises an input-busy flag. An internal sequencer consumes the byte after a configurable latency and then drops the flag. The host paces every multi-byte exchange by polling this flag and an output-ready flag.

The sequencer understands five commands: register read, register write, burst on, burst off and event query. Read and write reach a 256-entry byte register space. That space sits outside the block, on a plain register port: a one-cycle write strobe, and a read strobe whose data comes back combinationally in the same cycle. Other logic attaches its registers there. A third host offset holds an interrupt-control byte, which the host can read back and which is presented on an output.

Top module: `ec_host_mailbox`

## Requirements
- R1: Host offsets are 0x0 for data, 0x4 for status/command and 0x8 for interrupt control. The status byte has output-ready in bit 0, input-busy in bit 1, last-byte-was-command in bit 3, burst in bit 4, and zero in all other bits. After reset every flag is clear. A byte written to 0x8 reads back at 0x8 and does not raise input-busy.
- R2: A host write to 0x0 or 0x4 sets input-busy on the next clock edge. With no further write, input-busy clears exactly CONSUME_LAT cycles after the write edge.
- R3: Command 0x80 followed by an address byte gives one register read strobe at that address. The returned byte is loaded into the data port, and output-ready sets on the same edge that clears input-busy.
- R4: Command 0x81 followed by an address byte and then a data byte gives exactly one register write strobe, carrying that address and that data.
- R5: A host read of the data port clears output-ready.
- R6: A data byte that arrives with no command sequence open causes no register access and leaves output-ready unchanged.
- R7: A command byte other than 0x80–0x84 returns the sequencer to idle. Data bytes that follow it are discarded.
- R8: Command 0x82 sets the burst bit and loads 0x90 into the data port with output-ready set. Command 0x83 clears the burst bit.
- R9: Command 0x84 loads 0x00 into the data port with output-ready set.
- R10: A command byte written during an open sequence abandons that sequence without any register access and starts the new one.
- R11: The last-byte-was-command bit is 1 after a write to 0x4 and 0 after a write to 0x0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostAddr | input | HADDR_W | Host port offset |
| hostWrEn | input | 1 | Host write strobe |
| hostRdEn | input | 1 | Host read strobe (side effects only on the data port) |
| hostWrData | input | 8 | Host write byte |
| hostRdData | output | 8 | Host read byte, combinational on hostAddr |
| regAddr | output | REG_AW | Register space address |
| regWrEn | output | 1 | Register write strobe |
| regWrData | output | 8 | Register write byte |
| regRdEn | output | 1 | Register read strobe |
| regRdData | input | 8 | Register read byte, valid in the strobe cycle |
| intCtrl | output | 8 | Interrupt-control byte held for attached logic |

## Verification
Full read and write sequences are run at the lowest, highest and a middle address. A value written earlier and then read back separates real write strobes from lost or misaddressed ones. Lone data bytes, an unknown command followed by data, and a write sequence cut off by a read command each check that no stray register access occurs. The scoreboard flags any access that was not expected. Burst and query commands, together with cycle-exact sampling of input-busy, separate the flag timing and the content of the data port from those of the register path.

// File: rtl/ec_mbox_pkg.sv
package ec_mbox_pkg;
  localparam int BYTE_W = 8;

  localparam logic [BYTE_W-1:0] OP_READ      = 8'h80;
  localparam logic [BYTE_W-1:0] OP_WRITE     = 8'h81;
  localparam logic [BYTE_W-1:0] OP_BURST_ON  = 8'h82;
  localparam logic [BYTE_W-1:0] OP_BURST_OFF = 8'h83;
  localparam logic [BYTE_W-1:0] OP_QUERY     = 8'h84;
  localparam logic [BYTE_W-1:0] BURST_ACK    = 8'h90;
  localparam logic [BYTE_W-1:0] NO_EVENT     = 8'h00;

  localparam int ST_OUT_READY = 0;
  localparam int ST_IN_BUSY   = 1;
  localparam int ST_WAS_CMD   = 3;
  localparam int ST_BURST     = 4;

  typedef enum logic [1:0] {
    SEQ_IDLE,
    SEQ_RD_ADDR,
    SEQ_WR_ADDR,
    SEQ_WR_DATA
  } seqState_t;

  typedef struct packed {
    logic              consume;
    logic              loadOut;
    logic [BYTE_W-1:0] outVal;
    logic              burstSet;
    logic              burstClr;
  } ctrlStrobe_t;
endpackage

// File: rtl/ec_mbox_dp.sv
module ec_mbox_dp
  import ec_mbox_pkg::*;
#(
  parameter int HADDR_W  = 4,
  parameter int DATA_OFS = 0,
  parameter int CTRL_OFS = 4,
  parameter int INTC_OFS = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [HADDR_W-1:0] hostAddr,
  input  logic               hostWrEn,
  input  logic               hostRdEn,
  input  logic [BYTE_W-1:0]  hostWrData,
  output logic [BYTE_W-1:0]  hostRdData,
  input  ctrlStrobe_t        strb,
  output logic               hostByteWr,
  output logic [BYTE_W-1:0]  inByte,
  output logic               inIsCmd,
  output logic [BYTE_W-1:0]  intCtrl
);
  localparam logic [HADDR_W-1:0] DataA = HADDR_W'(DATA_OFS);
  localparam logic [HADDR_W-1:0] CtrlA = HADDR_W'(CTRL_OFS);
  localparam logic [HADDR_W-1:0] IntcA = HADDR_W'(INTC_OFS);

  logic dataSel, ctrlSel, intcSel, dataRd;
  logic ibf, obf, burst, cmdQ;
  logic [BYTE_W-1:0] inQ, outQ, intcQ, statusByte;

  assign dataSel    = hostAddr == DataA;
  assign ctrlSel    = hostAddr == CtrlA;
  assign intcSel    = hostAddr == IntcA;
  assign hostByteWr = hostWrEn && (dataSel || ctrlSel);
  assign dataRd     = hostRdEn && dataSel;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      inQ   <= '0;
      cmdQ  <= 1'b0;
      ibf   <= 1'b0;
      obf   <= 1'b0;
      burst <= 1'b0;
      outQ  <= '0;
      intcQ <= '0;
    end else begin
      if (hostByteWr) begin
        inQ  <= hostWrData;
        cmdQ <= ctrlSel;
      end
      if (hostWrEn && intcSel) intcQ <= hostWrData;
      if (hostByteWr)        ibf <= 1'b1;
      else if (strb.consume) ibf <= 1'b0;
      if (strb.loadOut) begin
        obf  <= 1'b1;
        outQ <= strb.outVal;
      end else if (dataRd) begin
        obf <= 1'b0;
      end
      if (strb.burstSet)      burst <= 1'b1;
      else if (strb.burstClr) burst <= 1'b0;
    end
  end

  always_comb begin
    statusByte               = '0;
    statusByte[ST_OUT_READY] = obf;
    statusByte[ST_IN_BUSY]   = ibf;
    statusByte[ST_WAS_CMD]   = cmdQ;
    statusByte[ST_BURST]     = burst;
    if (dataSel)      hostRdData = outQ;
    else if (ctrlSel) hostRdData = statusByte;
    else if (intcSel) hostRdData = intcQ;
    else              hostRdData = '0;
  end

  assign inByte  = inQ;
  assign inIsCmd = cmdQ;
  assign intCtrl = intcQ;

  // R2: a port write raises input-busy
  p_ibf_set_r2: assert property (@(posedge clk) disable iff (!rstN)
    hostByteWr |=> ibf);
  // R2: consumption drops input-busy unless a new byte lands
  p_ibf_clear_r2: assert property (@(posedge clk) disable iff (!rstN)
    (strb.consume && !hostByteWr) |=> !ibf);
  // R3: a load makes the byte visible with output-ready
  p_obf_load_r3: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadOut |=> (obf && outQ == $past(strb.outVal)));
  // R5: host data read releases output-ready
  p_obf_clear_r5: assert property (@(posedge clk) disable iff (!rstN)
    (dataRd && !strb.loadOut) |=> !obf);
  // R8: burst set and clear are never requested together
  p_burst_excl_r8: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.burstSet && strb.burstClr));
endmodule

// File: rtl/ec_mbox_ctrl.sv
module ec_mbox_ctrl
  import ec_mbox_pkg::*;
#(
  parameter int CONSUME_LAT = 2,
  parameter int REG_AW      = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostByteWr,
  input  logic [BYTE_W-1:0] inByte,
  input  logic              inIsCmd,
  input  logic [BYTE_W-1:0] regRdData,
  output ctrlStrobe_t       strb,
  output logic [REG_AW-1:0] regAddr,
  output logic              regWrEn,
  output logic [BYTE_W-1:0] regWrData,
  output logic              regRdEn
);
  localparam int LAT   = (CONSUME_LAT < 1) ? 1 : CONSUME_LAT;
  localparam int CNT_W = $clog2(LAT + 1);
  localparam logic [CNT_W-1:0] LatV = CNT_W'(LAT);

  logic [CNT_W-1:0]  latCnt;
  logic              consume;
  seqState_t         state, nextState;
  logic [REG_AW-1:0] addrQ;
  logic              addrLoad;

  assign consume = (latCnt == CNT_W'(1)) && !hostByteWr;

  always_ff @(posedge clk) begin
    if (!rstN)                 latCnt <= '0;
    else if (hostByteWr)       latCnt <= LatV;
    else if (latCnt != '0)     latCnt <= latCnt - CNT_W'(1);
  end

  always_comb begin
    strb          = '0;
    strb.consume  = consume;
    nextState     = state;
    addrLoad      = 1'b0;
    regWrEn       = 1'b0;
    regRdEn       = 1'b0;
    regAddr       = addrQ;
    regWrData     = inByte;
    if (consume) begin
      if (inIsCmd) begin
        nextState = SEQ_IDLE;
        case (inByte)
          OP_READ:      nextState = SEQ_RD_ADDR;
          OP_WRITE:     nextState = SEQ_WR_ADDR;
          OP_BURST_ON: begin
            strb.burstSet = 1'b1;
            strb.loadOut  = 1'b1;
            strb.outVal   = BURST_ACK;
          end
          OP_BURST_OFF: strb.burstClr = 1'b1;
          OP_QUERY: begin
            strb.loadOut = 1'b1;
            strb.outVal  = NO_EVENT;
          end
          default:      nextState = SEQ_IDLE;
        endcase
      end else begin
        case (state)
          SEQ_RD_ADDR: begin
            regRdEn      = 1'b1;
            regAddr      = REG_AW'(inByte);
            strb.loadOut = 1'b1;
            strb.outVal  = regRdData;
            nextState    = SEQ_IDLE;
          end
          SEQ_WR_ADDR: begin
            addrLoad  = 1'b1;
            nextState = SEQ_WR_DATA;
          end
          SEQ_WR_DATA: begin
            regWrEn   = 1'b1;
            nextState = SEQ_IDLE;
          end
          default:     nextState = SEQ_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= SEQ_IDLE;
      addrQ <= '0;
    end else begin
      state <= nextState;
      if (addrLoad) addrQ <= REG_AW'(inByte);
    end
  end

  // R2: the consume countdown never exceeds the configured latency
  p_lat_bound_r2: assert property (@(posedge clk) disable iff (!rstN)
    latCnt <= LatV);
  // R4: at most one register access per cycle
  p_one_access_r4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({regWrEn, regRdEn}));
  // R6: a data byte seen while idle is dropped silently
  p_idle_drop_r6: assert property (@(posedge clk) disable iff (!rstN)
    (consume && !inIsCmd && state == SEQ_IDLE) |-> !(regWrEn || regRdEn || strb.loadOut));
  // R10: a command byte never reaches the register space
  p_cmd_no_access_r10: assert property (@(posedge clk) disable iff (!rstN)
    (consume && inIsCmd) |-> !(regWrEn || regRdEn));
  // R7: an unknown command leaves the sequencer idle
  p_unknown_idle_r7: assert property (@(posedge clk) disable iff (!rstN)
    (consume && inIsCmd && (inByte < OP_READ || inByte > OP_QUERY)) |=> state == SEQ_IDLE);
endmodule

// File: rtl/ec_host_mailbox.sv
module ec_host_mailbox
  import ec_mbox_pkg::*;
#(
  parameter int HADDR_W     = 4,
  parameter int DATA_OFS    = 0,
  parameter int CTRL_OFS    = 4,
  parameter int INTC_OFS    = 8,
  parameter int CONSUME_LAT = 2,
  parameter int REG_AW      = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [HADDR_W-1:0] hostAddr,
  input  logic               hostWrEn,
  input  logic               hostRdEn,
  input  logic [7:0]         hostWrData,
  output logic [7:0]         hostRdData,
  output logic [REG_AW-1:0]  regAddr,
  output logic               regWrEn,
  output logic [7:0]         regWrData,
  output logic               regRdEn,
  input  logic [7:0]         regRdData,
  output logic [7:0]         intCtrl
);
  ctrlStrobe_t       strb;
  logic              hostByteWr;
  logic [BYTE_W-1:0] inByte;
  logic              inIsCmd;

  ec_mbox_dp #(
    .HADDR_W(HADDR_W), .DATA_OFS(DATA_OFS), .CTRL_OFS(CTRL_OFS), .INTC_OFS(INTC_OFS)
  ) u_dp (
    .clk(clk), .rstN(rstN), .hostAddr(hostAddr), .hostWrEn(hostWrEn),
    .hostRdEn(hostRdEn), .hostWrData(hostWrData), .hostRdData(hostRdData),
    .strb(strb), .hostByteWr(hostByteWr), .inByte(inByte), .inIsCmd(inIsCmd),
    .intCtrl(intCtrl)
  );

  ec_mbox_ctrl #(
    .CONSUME_LAT(CONSUME_LAT), .REG_AW(REG_AW)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .hostByteWr(hostByteWr), .inByte(inByte),
    .inIsCmd(inIsCmd), .regRdData(regRdData), .strb(strb), .regAddr(regAddr),
    .regWrEn(regWrEn), .regWrData(regWrData), .regRdEn(regRdEn)
  );
endmodule

// File: tb/sim_ec_host_mailbox.sv
module sim_ec_host_mailbox;
  localparam int LAT = 2;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [3:0] hostAddr = '0;
  logic       hostWrEn = 1'b0, hostRdEn = 1'b0;
  logic [7:0] hostWrData = '0, hostRdData;
  logic [7:0] regAddr, regWrData, regRdData, intCtrl;
  logic       regWrEn, regRdEn;

  int checks = 0, failures = 0;
  bit done = 0;

  typedef struct { bit wr; bit [7:0] a; bit [7:0] d; } acc_t;
  acc_t expQ[$];
  logic [7:0] mem [256];
  logic [7:0] expMem [256];
  logic [7:0] lastStatus;

  always #2 clk = ~clk;

  ec_host_mailbox #(.CONSUME_LAT(LAT)) u0 (
    .clk(clk), .rstN(rstN), .hostAddr(hostAddr), .hostWrEn(hostWrEn),
    .hostRdEn(hostRdEn), .hostWrData(hostWrData), .hostRdData(hostRdData),
    .regAddr(regAddr), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdEn(regRdEn), .regRdData(regRdData), .intCtrl(intCtrl)
  );

  assign regRdData = mem[regAddr];
  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 256; i++) mem[i] <= 8'h00;
    end else if (regWrEn) begin
      mem[regAddr] <= regWrData;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: compare every register access against the scoreboard
  always @(negedge clk) begin
    if (rstN && (regWrEn || regRdEn)) begin
      checks++;
      if (expQ.size() == 0) begin
        failures++;
        $display("FAIL R6/R7/R10 unexpected access actual=%0h expected=none", regAddr);
      end else begin
        acc_t e;
        e = expQ.pop_front();
        if (e.wr != regWrEn || e.a != regAddr || (e.wr && e.d != regWrData)) begin
          failures++;
          $display("FAIL R3/R4 access actual=%0b/%0h/%0h expected=%0b/%0h/%0h",
                   regWrEn, regAddr, regWrData, e.wr, e.a, e.d);
        end
      end
    end
  end

  // all tasks start and end 1 ns after a rising edge
  task automatic hostWrite(input logic [3:0] a, input logic [7:0] d);
    hostAddr = a; hostWrData = d; hostWrEn = 1'b1;
    @(posedge clk); #1;
    hostWrEn = 1'b0;
  endtask

  task automatic hostRead(input logic [3:0] a, input bit side, output logic [7:0] v);
    hostAddr = a; hostRdEn = side;
    @(negedge clk); v = hostRdData;
    @(posedge clk); #1;
    hostRdEn = 1'b0;
  endtask

  task automatic waitIbf();
    hostAddr = 4'h4;
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      lastStatus = hostRdData;
      if (!hostRdData[1]) break;
    end
    @(posedge clk); #1;
  endtask

  task automatic putByte(input logic [3:0] a, input logic [7:0] d);
    hostWrite(a, d);
    waitIbf();
  endtask

  task automatic ecWrite(input logic [7:0] a, input logic [7:0] d);
    acc_t e;
    e.wr = 1; e.a = a; e.d = d;
    expQ.push_back(e);
    expMem[a] = d;
    putByte(4'h4, 8'h81);
    putByte(4'h0, a);
    putByte(4'h0, d);
  endtask

  task automatic ecRead(input logic [7:0] a, input string req);
    acc_t e;
    logic [7:0] v;
    e.wr = 0; e.a = a; e.d = 0;
    expQ.push_back(e);
    putByte(4'h4, 8'h80);
    putByte(4'h0, a);
    check("R3 output-ready with busy drop", lastStatus[0], 1);
    hostRead(4'h0, 1'b1, v);
    check(req, v, expMem[a]);
    hostRead(4'h4, 1'b0, v);
    check("R5 output-ready cleared", v[0], 0);
  endtask

  initial begin
    logic [7:0] v;
    for (int i = 0; i < 256; i++) expMem[i] = 8'h00;
    repeat (3) @(posedge clk);
    rstN = 1'b1;
    #1;

    hostRead(4'h4, 1'b0, v);
    check("R1 status after reset", v, 8'h00);
    hostRead(4'h0, 1'b0, v);
    check("R1 data after reset", v, 8'h00);

    hostWrite(4'h8, 8'h5A);
    hostRead(4'h8, 1'b0, v);
    check("R1 intctrl readback", v, 8'h5A);
    check("R1 intctrl port", intCtrl, 8'h5A);
    hostRead(4'h4, 1'b0, v);
    check("R1 intctrl write leaves busy clear", v[1], 0);

    // R2 cycle timing of input-busy, R11 command flag
    hostWrite(4'h4, 8'h83);
    hostAddr = 4'h4;
    for (int k = 0; k < LAT; k++) begin
      @(negedge clk);
      check("R2 busy held", hostRdData[1], 1);
    end
    @(negedge clk);
    check("R2 busy cleared after latency", hostRdData[1], 0);
    check("R11 command flag set", hostRdData[3], 1);
    @(posedge clk); #1;

    ecWrite(8'h10, 8'hA5);
    hostRead(4'h4, 1'b0, v);
    check("R11 command flag clear after data", v[3], 0);
    ecRead(8'h10, "R3 read mid address");
    ecWrite(8'hFF, 8'h3C);
    ecWrite(8'h00, 8'hC3);
    ecRead(8'hFF, "R4 read back top address");
    ecRead(8'h00, "R4 read back bottom address");

    // R6 stray data byte while idle
    putByte(4'h0, 8'h77);
    check("R6 stray byte output-ready", lastStatus[0], 0);
    ecRead(8'h77, "R6 stray byte left space unchanged");

    // R7 unknown command then data
    putByte(4'h4, 8'h85);
    putByte(4'h0, 8'h20);
    putByte(4'h0, 8'h11);
    ecRead(8'h20, "R7 unknown command no write");

    // R8 burst on/off
    putByte(4'h4, 8'h82);
    check("R8 burst bit set", lastStatus[4], 1);
    check("R8 output-ready on burst", lastStatus[0], 1);
    hostRead(4'h0, 1'b1, v);
    check("R8 burst ack byte", v, 8'h90);
    putByte(4'h4, 8'h83);
    check("R8 burst bit cleared", lastStatus[4], 0);

    // R9 query
    putByte(4'h4, 8'h84);
    check("R9 query output-ready", lastStatus[0], 1);
    hostRead(4'h0, 1'b1, v);
    check("R9 query byte", v, 8'h00);

    // R10 write sequence aborted by read command
    putByte(4'h4, 8'h81);
    putByte(4'h0, 8'h30);
    ecRead(8'h30, "R10 aborted write left byte unchanged");

    repeat (4) @(posedge clk);
    check("R4 scoreboard drained", expQ.size(), 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule